// File: doc/BRIEF.md
# RC5 Infrared Frame Transmitter

This block turns a 14-bit RC5 command word into the light pattern for a single infrared LED. The host offers a word on a valid/ready handshake. The block then sends the word bit by bit, least significant bit first. Each bit is made of two half-bit slots of equal length. A burst slot carries a gated carrier, and an idle slot holds the output low. The carrier generator and the half-bit timer are both counters clocked from the system clock. Their divisors are worked out at elaboration from the clock frequency parameter.

The block also owns the toggle bit of the protocol. The host marks each offered word either as a new key press or as a repeat of a key that is still held. The block keeps the toggle value across repeats and inverts it on each new press. It also forces the two framing bits at the top of the word to 1. A word whose first bit is 0 would not start a legal frame, so it is taken off the interface and dropped without being sent.

Top module: `rc5_ir_sender`

## Requirements
- R1: `in_ready` is high only while no frame is being sent. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_valid` has no effect while a frame is in progress.
- R2: An accepted frame is sent as 14 bits, least significant bit first, each bit as two half-bit slots. A 1 is sent as an idle slot followed by a burst slot, and a 0 as a burst slot followed by an idle slot. The first slot starts in the cycle after the accepting edge.
- R3: One carrier period lasts round(CLK_HZ / CARRIER_HZ) clocks. Within each period the output is high for the first floor(period / 2) clocks. A half-bit slot lasts exactly BURST_CYCLES carrier periods, so a burst slot holds exactly BURST_CYCLES carrier pulses and an idle slot holds none.
- R4: A word whose bit 0 is 0 is consumed but not sent. In the following cycle `rejected` is high for one clock and `in_ready` stays high. The output stays low, and the stored toggle value is unchanged.
- R5: Bits 12 and 13 of the sent frame are always 1, whatever the host supplies in those positions.
- R6: Bit 2 of the sent frame is the toggle bit, and the host's value in bit 2 is ignored. The stored toggle is 0 after reset. A word accepted with `in_new_press` high inverts the stored toggle and sends the new value. A word accepted with `in_new_press` low sends the stored value unchanged.
- R7: `ir_out` is low whenever no frame is in progress.
- R8: `done` is high for exactly one clock, in the cycle after the last slot of bit 13 ends. In that same cycle `in_ready` is high, so the next word can be accepted back to back.
- R9: After reset, `ir_out`, `done` and `rejected` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a frame word |
| in_ready | output | 1 | Block is idle and can take a word |
| in_word | input | 14 | Frame word, bit 0 sent first |
| in_new_press | input | 1 | Word belongs to a new key press (toggle inverts) |
| ir_out | output | 1 | Modulated LED drive |
| done | output | 1 | One-clock pulse at end of frame |
| rejected | output | 1 | One-clock pulse when a word with bit 0 clear is dropped |

## Verification
The end-of-frame pulse and the acceptance of the next word can fall in the same cycle. The bench provokes this by raising `in_valid` with a second word just after the first word is accepted, and holding it through the whole first frame. In the done cycle it requires `done` and `in_ready` to be high together. It then decodes the second frame, with its own toggle handling, starting exactly one cycle later. This confirms that the waiting word neither disturbed the first frame nor was lost.

// File: rtl/rc5_ir_sender.sv
module rc5_ir_sender #(
  parameter int CLK_HZ       = 48_000_000,
  parameter int CARRIER_HZ   = 36_000,
  parameter int BURST_CYCLES = 32,
  parameter int TOGGLE_POS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [13:0] in_word,
  input  logic        in_new_press,
  output logic        ir_out,
  output logic        done,
  output logic        rejected
);
  localparam int FRAME_BITS = 14;
  localparam int CAR_DIV    = (2 * CLK_HZ + CARRIER_HZ) / (2 * CARRIER_HZ);
  localparam int CAR_W      = $clog2(CAR_DIV + 1);
  localparam int PUL_W      = $clog2(BURST_CYCLES + 1);
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CAR_W-1:0] CAR_LAST = CAR_W'(CAR_DIV - 1);
  localparam logic [CAR_W-1:0] CAR_HIGH = CAR_W'(CAR_DIV / 2);
  localparam logic [PUL_W-1:0] PUL_LAST = PUL_W'(BURST_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic                  busy, phase, tog_q, done_q, rej_q, next_tog;
  logic [FRAME_BITS-1:0] shreg, frame;
  logic [CAR_W-1:0]      car_cnt;
  logic [PUL_W-1:0]      pul_cnt;
  logic [BIT_W-1:0]      bit_cnt;

  assign in_ready = !busy;
  assign done     = done_q;
  assign rejected = rej_q;
  assign next_tog = in_new_press ? !tog_q : tog_q;
  assign ir_out   = busy && (phase == shreg[0]) && (car_cnt < CAR_HIGH);

  always_comb begin
    frame = in_word;
    frame[FRAME_BITS-1] = 1'b1;
    frame[FRAME_BITS-2] = 1'b1;
    frame[TOGGLE_POS]   = next_tog;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      tog_q   <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      shreg   <= '0;
      car_cnt <= '0;
      pul_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          if (in_word[0]) begin
            busy    <= 1'b1;
            shreg   <= frame;
            tog_q   <= next_tog;
            phase   <= 1'b0;
            car_cnt <= '0;
            pul_cnt <= '0;
            bit_cnt <= '0;
          end else begin
            rej_q <= 1'b1;
          end
        end
      end else if (car_cnt != CAR_LAST) begin
        car_cnt <= car_cnt + 1'b1;
      end else begin
        car_cnt <= '0;
        if (pul_cnt != PUL_LAST) begin
          pul_cnt <= pul_cnt + 1'b1;
        end else begin
          pul_cnt <= '0;
          phase   <= !phase;
          if (phase) begin
            if (bit_cnt == BIT_LAST) begin
              busy   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= shreg >> 1;
            end
          end
        end
      end
    end
  end

  assert_idle_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_start_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));
  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (!busy && !ir_out));
  assert_framing_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (shreg[FRAME_BITS-1] && shreg[FRAME_BITS-2] && shreg[0]));
endmodule

// File: tb/rc5_ir_sender_tb.sv
module rc5_ir_sender_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 10;
  localparam int HIGHS = 5;
  localparam int BURST = 4;
  localparam int HALF  = DIV * BURST;
  localparam int NVEC  = 7;
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {1'b1, 14'h0001}, {1'b0, 14'h3FFF}, {1'b0, 14'h0AAB},
    {1'b1, 14'h1555}, {1'b1, 14'h0005}, {1'b0, 14'h2C39}, {1'b1, 14'h03F7}};

  logic clk = 0, rst_n = 0, in_valid = 0, in_new_press = 0;
  logic [13:0] in_word = '0;
  logic in_ready, ir_out, done, rejected;
  int errors = 0, checks = 0;
  logic model_tog = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  rc5_ir_sender #(.CLK_HZ(360_000), .CARRIER_HZ(36_000), .BURST_CYCLES(BURST)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_new_press(in_new_press), .ir_out(ir_out),
    .done(done), .rejected(rejected));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] expect_word(input logic [13:0] w, input logic press);
    logic [13:0] e = w;
    if (press) model_tog = !model_tog;
    e[13] = 1'b1; e[12] = 1'b1; e[2] = model_tog;
    return e;
  endfunction

  task automatic capture(input logic [13:0] exp);
    int cnt [0:27];
    int bad_half = 0, ready_hi = 0, done_hi = 0;
    logic [13:0] got = '0;
    for (int h = 0; h < 28; h++) begin
      cnt[h] = 0;
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        if (ir_out) cnt[h]++;
        if (in_ready) ready_hi++;
        if (done) done_hi++;
      end
    end
    for (int b = 0; b < 14; b++) begin
      got[b] = (cnt[2*b+1] > 0);
      if (cnt[2*b]   != (exp[b] ? 0 : BURST*HIGHS)) bad_half++;
      if (cnt[2*b+1] != (exp[b] ? BURST*HIGHS : 0)) bad_half++;
    end
    check(got == exp, "R2 R5 R6 frame bits", got, exp);
    check(bad_half == 0, "R3 burst pulse count", bad_half, 0);
    check(ready_hi == 0, "R1 ready low while busy", ready_hi, 0);
    check(done_hi == 0, "R8 no early done", done_hi, 0);
    @(negedge clk);
    check(done == 1'b1, "R8 done after last slot", done, 1);
    check(in_ready == 1'b1, "R8 ready with done", in_ready, 1);
    check(ir_out == 1'b0, "R7 idle output low", ir_out, 0);
  endtask

  task automatic offer(input logic [13:0] w, input logic press);
    @(negedge clk);
    in_word = w; in_new_press = press; in_valid = 1;
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [13:0] e;
    int lit;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(in_ready == 1 && ir_out == 0 && done == 0 && rejected == 0,
          "R9 reset state", {in_ready, ir_out, done, rejected}, 4'b1000);

    for (int i = 0; i < NVEC; i++) begin
      e = expect_word(VEC[i][13:0], VEC[i][14]);
      offer(VEC[i][13:0], VEC[i][14]);
      capture(e);
    end

    // R4: rejected word, toggle kept
    offer(14'h3FFE, 1'b1);
    @(negedge clk);
    check(rejected == 1, "R4 reject pulse", rejected, 1);
    check(in_ready == 1, "R4 ready after reject", in_ready, 1);
    lit = 0;
    for (int c = 0; c < 3 * HALF; c++) begin
      @(negedge clk);
      if (ir_out || rejected) lit++;
    end
    check(lit == 0, "R4 R7 nothing sent", lit, 0);
    e = expect_word(14'h0801, 1'b0);
    offer(14'h0801, 1'b0);
    capture(e);

    // R8 R1: back-to-back with valid held through a frame
    e = expect_word(14'h1235, 1'b1);
    @(negedge clk);
    in_word = 14'h1235; in_new_press = 1; in_valid = 1;
    @(posedge clk);
    #1 in_word = 14'h0B0F; in_new_press = 1;
    capture(e);
    check(in_valid == 1, "R8 next word waiting in done cycle", in_valid, 1);
    e = expect_word(14'h0B0F, 1'b1);
    @(posedge clk);
    #1 in_valid = 0;
    capture(e);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule